// File: doc/BRIEF.md
# Pipeline Stall Detector for a Non-Forwarding Five-Stage Core

This block decides, every cycle, whether the instruction sitting in decode may advance. It serves a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback) that has no bypass paths. Any instruction that reads a register still owed by an older instruction in flight must therefore wait in decode. Branches and jumps settle their target only at the end of execute, so the front end also waits while one of them occupies execute.

The logic is purely combinational. Each pipeline stage presents its valid bit, opcode and function field, and the register fields that stage needs. Every stage's instruction is classified into which source fields it reads, which register it writes, and whether it redirects fetch. The single `stall` output is meant to hold the program counter and the fetch/decode register and to load a NOP bubble (valid cleared, write enables low) into the decode/execute register. The register file writes early in a cycle and reads late, so by default a writer in writeback needs no stall. A parameter can add the writeback comparison for a register file without that property.

Top module: `hzd_stall_unit`

## Requirements
- R1: With decode valid, `stall` is 1 in the same cycle when a valid execute-stage instruction writes a nonzero register that decode reads through rs or rt.
- R2: With decode valid, `stall` is 1 in the same cycle when a valid memory-stage instruction writes a nonzero register that decode reads through rs or rt.
- R3: With the default register file timing, a writer in writeback never raises `stall`, whatever its destination.
- R4: Register 0 never creates a dependency, even when both instructions name it.
- R5: The written register is rd for R-type ALU and shift instructions (opcode 0x00, funct 0x20–0x27, 0x2A, 0x2B, 0x00, 0x02). It is rt for I-type ALU ops (0x08–0x0E), lui (0x0F) and loads (0x20, 0x21, 0x23, 0x24, 0x25), and register 31 for jal (0x03). Stores (0x28, 0x29, 0x2B), beq/bne (0x04/0x05), j (0x02), jr (opcode 0x00, funct 0x08) and unknown encodings write nothing.
- R6: Only the fields an instruction actually reads are compared. R-type ALU ops, stores and beq/bne read rs and rt. Shifts (funct 0x00/0x02) read only rt. jr, I-type ALU ops and loads read only rs. lui, j, jal and unknown encodings read nothing. The funct field is ignored whenever the opcode is not 0x00.
- R7: With decode valid, `stall` is 1 while execute holds a valid beq, bne, j, jal or jr, whatever the register fields.
- R8: An invalid stage contributes nothing. With decode invalid, `stall` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_op | input | OP_W | Decode opcode |
| id_fn | input | FN_W | Decode function field |
| id_rs | input | REG_W | Decode first source field |
| id_rt | input | REG_W | Decode second source field |
| ex_valid | input | 1 | Execute stage holds a real instruction |
| ex_op | input | OP_W | Execute opcode |
| ex_fn | input | FN_W | Execute function field |
| ex_rt | input | REG_W | Execute rt field |
| ex_rd | input | REG_W | Execute rd field |
| mem_valid | input | 1 | Memory stage holds a real instruction |
| mem_op | input | OP_W | Memory opcode |
| mem_fn | input | FN_W | Memory function field |
| mem_rt | input | REG_W | Memory rt field |
| mem_rd | input | REG_W | Memory rd field |
| wb_valid | input | 1 | Writeback stage holds a real instruction |
| wb_op | input | OP_W | Writeback opcode |
| wb_fn | input | FN_W | Writeback function field |
| wb_rt | input | REG_W | Writeback rt field |
| wb_rd | input | REG_W | Writeback rd field |
| stall | output | 1 | Hold fetch and decode, bubble into execute |

## Verification
Sixteen instruction kinds are swept against one another, one older stage at a time. Each register field takes the values 0, 1 and 31, which exercises matches, mismatches, the zero register and the link register. The execute sweep separates control stalls from data stalls. The memory sweep, run with execute empty, shows that control stalls are tied to execute only. The writeback sweep must never stall. I-type kinds carry a funct value equal to jr's, and unused source and destination fields are set to matching values, so a decoder that reads the wrong field or trusts funct outside opcode 0x00 produces a wrong `stall`.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
   localparam int OPC_SPECIAL = 'h00;
   localparam int OPC_J       = 'h02;
   localparam int OPC_JAL     = 'h03;
   localparam int OPC_BEQ     = 'h04;
   localparam int OPC_BNE     = 'h05;
   localparam int OPC_ADDI    = 'h08;
   localparam int OPC_ADDIU   = 'h09;
   localparam int OPC_SLTI    = 'h0A;
   localparam int OPC_SLTIU   = 'h0B;
   localparam int OPC_ANDI    = 'h0C;
   localparam int OPC_ORI     = 'h0D;
   localparam int OPC_XORI    = 'h0E;
   localparam int OPC_LUI     = 'h0F;
   localparam int OPC_LB      = 'h20;
   localparam int OPC_LH      = 'h21;
   localparam int OPC_LW      = 'h23;
   localparam int OPC_LBU     = 'h24;
   localparam int OPC_LHU     = 'h25;
   localparam int OPC_SB      = 'h28;
   localparam int OPC_SH      = 'h29;
   localparam int OPC_SW      = 'h2B;

   localparam int FN_SLL  = 'h00;
   localparam int FN_SRL  = 'h02;
   localparam int FN_JR   = 'h08;
   localparam int FN_SLT  = 'h2A;
   localparam int FN_SLTU = 'h2B;

   typedef enum logic [3:0] {
      CLS_NONE,
      CLS_RRR,
      CLS_SHIFT,
      CLS_JR,
      CLS_IALU,
      CLS_LUI,
      CLS_LOAD,
      CLS_STORE,
      CLS_BRANCH,
      CLS_JUMP,
      CLS_JLINK
   } icls_e;
endpackage

// File: rtl/hzd_decode.sv
module hzd_decode
   import hzd_pkg::*;
#(
   parameter int unsigned REG_W    = 5,
   parameter int unsigned OP_W     = 6,
   parameter int unsigned FN_W     = 6,
   parameter int unsigned LINK_REG = 31
) (
   input  logic [OP_W-1:0]  op,
   input  logic [FN_W-1:0]  fn,
   input  logic [REG_W-1:0] rt,
   input  logic [REG_W-1:0] rd,
   output logic             use_rs,
   output logic             use_rt,
   output logic [REG_W-1:0] dst,
   output logic             is_ctrl
);
   icls_e cls;

   always_comb begin
      cls = CLS_NONE;
      if (op == OP_W'(OPC_SPECIAL)) begin
         if (fn == FN_W'(FN_SLL) || fn == FN_W'(FN_SRL))
            cls = CLS_SHIFT;
         else if (fn == FN_W'(FN_JR))
            cls = CLS_JR;
         else if ((fn >= FN_W'('h20) && fn <= FN_W'('h27)) ||
                  fn == FN_W'(FN_SLT) || fn == FN_W'(FN_SLTU))
            cls = CLS_RRR;
      end else begin
         case (op)
            OP_W'(OPC_J):     cls = CLS_JUMP;
            OP_W'(OPC_JAL):   cls = CLS_JLINK;
            OP_W'(OPC_BEQ),
            OP_W'(OPC_BNE):   cls = CLS_BRANCH;
            OP_W'(OPC_ADDI),
            OP_W'(OPC_ADDIU),
            OP_W'(OPC_SLTI),
            OP_W'(OPC_SLTIU),
            OP_W'(OPC_ANDI),
            OP_W'(OPC_ORI),
            OP_W'(OPC_XORI):  cls = CLS_IALU;
            OP_W'(OPC_LUI):   cls = CLS_LUI;
            OP_W'(OPC_LB),
            OP_W'(OPC_LH),
            OP_W'(OPC_LW),
            OP_W'(OPC_LBU),
            OP_W'(OPC_LHU):   cls = CLS_LOAD;
            OP_W'(OPC_SB),
            OP_W'(OPC_SH),
            OP_W'(OPC_SW):    cls = CLS_STORE;
            default:          cls = CLS_NONE;
         endcase
      end
   end

   always_comb begin
      use_rs  = 1'b0;
      use_rt  = 1'b0;
      dst     = '0;
      is_ctrl = 1'b0;
      unique case (cls)
         CLS_RRR:    begin use_rs = 1'b1; use_rt = 1'b1; dst = rd; end
         CLS_SHIFT:  begin use_rt = 1'b1; dst = rd; end
         CLS_JR:     begin use_rs = 1'b1; is_ctrl = 1'b1; end
         CLS_IALU:   begin use_rs = 1'b1; dst = rt; end
         CLS_LUI:    begin dst = rt; end
         CLS_LOAD:   begin use_rs = 1'b1; dst = rt; end
         CLS_STORE:  begin use_rs = 1'b1; use_rt = 1'b1; end
         CLS_BRANCH: begin use_rs = 1'b1; use_rt = 1'b1; is_ctrl = 1'b1; end
         CLS_JUMP:   begin is_ctrl = 1'b1; end
         CLS_JLINK:  begin is_ctrl = 1'b1; dst = REG_W'(LINK_REG); end
         default:    begin end
      endcase
   end
endmodule

// File: rtl/hzd_raw_cmp.sv
module hzd_raw_cmp #(
   parameter int unsigned REG_W = 5
) (
   input  logic [REG_W-1:0] rd_rs,
   input  logic             rd_rs_use,
   input  logic [REG_W-1:0] rd_rt,
   input  logic             rd_rt_use,
   input  logic             wr_valid,
   input  logic [REG_W-1:0] wr_dst,
   output logic             hit
);
   logic dst_live;
   logic rs_eq;
   logic rt_eq;

   assign dst_live = wr_valid && (wr_dst != '0);
   assign rs_eq    = rd_rs_use && (rd_rs == wr_dst);
   assign rt_eq    = rd_rt_use && (rd_rt == wr_dst);
   assign hit      = dst_live && (rs_eq || rt_eq);
endmodule

// File: rtl/hzd_stall_unit.sv
module hzd_stall_unit #(
   parameter int unsigned REG_W          = 5,
   parameter int unsigned OP_W           = 6,
   parameter int unsigned FN_W           = 6,
   parameter int unsigned LINK_REG       = 31,
   parameter int unsigned RF_WRITE_FIRST = 1
) (
   input  logic             id_valid,
   input  logic [OP_W-1:0]  id_op,
   input  logic [FN_W-1:0]  id_fn,
   input  logic [REG_W-1:0] id_rs,
   input  logic [REG_W-1:0] id_rt,
   input  logic             ex_valid,
   input  logic [OP_W-1:0]  ex_op,
   input  logic [FN_W-1:0]  ex_fn,
   input  logic [REG_W-1:0] ex_rt,
   input  logic [REG_W-1:0] ex_rd,
   input  logic             mem_valid,
   input  logic [OP_W-1:0]  mem_op,
   input  logic [FN_W-1:0]  mem_fn,
   input  logic [REG_W-1:0] mem_rt,
   input  logic [REG_W-1:0] mem_rd,
   input  logic             wb_valid,
   input  logic [OP_W-1:0]  wb_op,
   input  logic [FN_W-1:0]  wb_fn,
   input  logic [REG_W-1:0] wb_rt,
   input  logic [REG_W-1:0] wb_rd,
   output logic             stall
);
   localparam int unsigned NST      = 4;
   localparam int unsigned LAST_CMP = (RF_WRITE_FIRST != 0) ? 2 : 3;

   if (REG_W < 2) begin : g_bad_reg_w
      $error("hzd_stall_unit: REG_W must be at least 2");
   end
   if (OP_W < 6) begin : g_bad_op_w
      $error("hzd_stall_unit: OP_W must hold a 6-bit opcode");
   end
   if (FN_W < 6) begin : g_bad_fn_w
      $error("hzd_stall_unit: FN_W must hold a 6-bit function code");
   end
   if (LINK_REG == 0 || LINK_REG >= (1 << REG_W)) begin : g_bad_link
      $error("hzd_stall_unit: LINK_REG out of register range");
   end

   logic [NST-1:0]            st_valid;
   logic [NST-1:0][OP_W-1:0]  st_op;
   logic [NST-1:0][FN_W-1:0]  st_fn;
   logic [NST-1:0][REG_W-1:0] st_rt;
   logic [NST-1:0][REG_W-1:0] st_rd;

   assign st_valid = {wb_valid, mem_valid, ex_valid, id_valid};
   assign st_op    = {wb_op, mem_op, ex_op, id_op};
   assign st_fn    = {wb_fn, mem_fn, ex_fn, id_fn};
   assign st_rt    = {wb_rt, mem_rt, ex_rt, id_rt};
   assign st_rd    = {wb_rd, mem_rd, ex_rd, REG_W'(0)};

   logic [NST-1:0]            use_rs;
   logic [NST-1:0]            use_rt;
   logic [NST-1:0][REG_W-1:0] dst;
   logic [NST-1:0]            is_ctrl;

   for (genvar s = 0; s < NST; s++) begin : g_dec
      hzd_decode #(
         .REG_W   (REG_W),
         .OP_W    (OP_W),
         .FN_W    (FN_W),
         .LINK_REG(LINK_REG)
      ) u_dec (
         .op     (st_op[s]),
         .fn     (st_fn[s]),
         .rt     (st_rt[s]),
         .rd     (st_rd[s]),
         .use_rs (use_rs[s]),
         .use_rt (use_rt[s]),
         .dst    (dst[s]),
         .is_ctrl(is_ctrl[s])
      );
   end

   logic [NST-1:1] raw_hit;

   for (genvar s = 1; s < NST; s++) begin : g_cmp
      if (s <= LAST_CMP) begin : g_on
         hzd_raw_cmp #(
            .REG_W(REG_W)
         ) u_cmp (
            .rd_rs    (id_rs),
            .rd_rs_use(use_rs[0]),
            .rd_rt    (id_rt),
            .rd_rt_use(use_rt[0]),
            .wr_valid (st_valid[s]),
            .wr_dst   (dst[s]),
            .hit      (raw_hit[s])
         );
      end else begin : g_off
         logic unused_late;
         assign unused_late = ^{st_valid[s], dst[s]};
         assign raw_hit[s]  = 1'b0;
      end
   end

   logic ex_is_ctrl;
   assign ex_is_ctrl = st_valid[1] & is_ctrl[1];

   assign stall = st_valid[0] & ((|raw_hit) | ex_is_ctrl);

   logic unused_dec;
   assign unused_dec = ^{use_rs[NST-1:1], use_rt[NST-1:1], dst[0],
                         is_ctrl[0], is_ctrl[NST-1:2]};
endmodule

// File: rtl/hzd_stall_chk.sv
module hzd_stall_chk #(
   parameter int unsigned REG_W          = 5,
   parameter int unsigned RF_WRITE_FIRST = 1
) (
   input logic             id_valid,
   input logic [REG_W-1:0] id_rs,
   input logic [REG_W-1:0] id_rt,
   input logic             ex_ctrl,
   input logic [3:1]       raw_hit,
   input logic             stall
);
   always_comb begin
      if (!id_valid) begin
         p_idle_no_stall_r8: assert (!stall)
            else $error("R8: stall raised with empty decode");
      end
      if (id_valid && raw_hit[1]) begin
         p_raw_ex_r1: assert (stall)
            else $error("R1: execute dependency did not stall");
      end
      if (id_valid && raw_hit[2]) begin
         p_raw_mem_r2: assert (stall)
            else $error("R2: memory dependency did not stall");
      end
      if (RF_WRITE_FIRST != 0 && id_valid && !raw_hit[1] && !raw_hit[2] && !ex_ctrl) begin
         p_wb_free_r3: assert (!stall)
            else $error("R3: stall without an execute or memory cause");
      end
      if (id_rs == '0 && id_rt == '0) begin
         p_zero_reg_r4: assert (raw_hit == 3'b000)
            else $error("R4: register zero produced a dependency");
      end
      if (id_valid && ex_ctrl) begin
         p_ctrl_hold_r7: assert (stall)
            else $error("R7: control instruction in execute did not stall");
      end
   end
endmodule

bind hzd_stall_unit hzd_stall_chk #(
   .REG_W         (REG_W),
   .RF_WRITE_FIRST(RF_WRITE_FIRST)
) u_chk (
   .id_valid(id_valid),
   .id_rs   (id_rs),
   .id_rt   (id_rt),
   .ex_ctrl (ex_is_ctrl),
   .raw_hit (raw_hit),
   .stall   (stall)
);

// File: tb/hzd_stall_unit_tb.sv
module hzd_stall_unit_tb;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n;
   int   checks = 0;
   int   errors = 0;
   int   cycles = 0;

   logic       id_valid, ex_valid, mem_valid, wb_valid;
   logic [5:0] id_op, id_fn, ex_op, ex_fn, mem_op, mem_fn, wb_op, wb_fn;
   logic [4:0] id_rs, id_rt, ex_rt, ex_rd, mem_rt, mem_rd, wb_rt, wb_rd;
   logic       stall;

   hzd_stall_unit u_dut (
      .id_valid(id_valid), .id_op(id_op), .id_fn(id_fn), .id_rs(id_rs), .id_rt(id_rt),
      .ex_valid(ex_valid), .ex_op(ex_op), .ex_fn(ex_fn), .ex_rt(ex_rt), .ex_rd(ex_rd),
      .mem_valid(mem_valid), .mem_op(mem_op), .mem_fn(mem_fn), .mem_rt(mem_rt), .mem_rd(mem_rd),
      .wb_valid(wb_valid), .wb_op(wb_op), .wb_fn(wb_fn), .wb_rt(wb_rt), .wb_rd(wb_rd),
      .stall(stall)
   );

   // kind table: opcode, funct, reads rs, reads rt, dest mode (0 none,1 rd,2 rt,3 r31), control
   function automatic void kind_info(input int k, output logic [5:0] op, output logic [5:0] fn,
                                     output bit urs, output bit urt, output int dm, output bit ctl);
      op = 6'h00; fn = 6'h08; urs = 0; urt = 0; dm = 0; ctl = 0;
      case (k)
         0:  begin fn = 6'h20; urs = 1; urt = 1; dm = 1; end   // add
         1:  begin fn = 6'h22; urs = 1; urt = 1; dm = 1; end   // sub
         2:  begin fn = 6'h2A; urs = 1; urt = 1; dm = 1; end   // slt
         3:  begin fn = 6'h00; urt = 1; dm = 1; end            // sll
         4:  begin fn = 6'h08; urs = 1; ctl = 1; end           // jr
         5:  begin op = 6'h08; urs = 1; dm = 2; end            // addi
         6:  begin op = 6'h0D; urs = 1; dm = 2; end            // ori
         7:  begin op = 6'h0F; dm = 2; end                     // lui
         8:  begin op = 6'h23; urs = 1; dm = 2; end            // lw
         9:  begin op = 6'h2B; urs = 1; urt = 1; end           // sw
         10: begin op = 6'h04; urs = 1; urt = 1; ctl = 1; end  // beq
         11: begin op = 6'h05; urs = 1; urt = 1; ctl = 1; end  // bne
         12: begin op = 6'h02; ctl = 1; end                    // j
         13: begin op = 6'h03; dm = 3; ctl = 1; end            // jal
         14: begin fn = 6'h3F; end                             // unknown funct
         default: begin op = 6'h3F; end                        // unknown opcode
      endcase
   endfunction

   function automatic logic [4:0] regval(input int i);
      return (i == 0) ? 5'd0 : (i == 1) ? 5'd1 : 5'd31;
   endfunction

   function automatic logic [4:0] dest_of(input int dm, input logic [4:0] rt, input logic [4:0] rd);
      case (dm)
         1: return rd;
         2: return rt;
         3: return 5'd31;
         default: return 5'd0;
      endcase
   endfunction

   task automatic clear_all();
      id_valid = 0; ex_valid = 0; mem_valid = 0; wb_valid = 0;
      id_op = 0; id_fn = 0; id_rs = 0; id_rt = 0;
      ex_op = 0; ex_fn = 0; ex_rt = 0; ex_rd = 0;
      mem_op = 0; mem_fn = 0; mem_rt = 0; mem_rd = 0;
      wb_op = 0; wb_fn = 0; wb_rt = 0; wb_rd = 0;
   endtask

   task automatic check(input bit exp, input string tag, input string what);
      checks++;
      if (stall !== exp) begin
         errors++;
         $display("FAIL %s %s: stall=%0b expected %0b", tag, what, stall, exp);
      end
   endtask

   task automatic set_stage(input int st, input bit v, input logic [5:0] op, input logic [5:0] fn,
                            input logic [4:0] rt, input logic [4:0] rd);
      case (st)
         1: begin ex_valid = v;  ex_op = op;  ex_fn = fn;  ex_rt = rt;  ex_rd = rd;  end
         2: begin mem_valid = v; mem_op = op; mem_fn = fn; mem_rt = rt; mem_rd = rd; end
         default: begin wb_valid = v; wb_op = op; wb_fn = fn; wb_rt = rt; wb_rd = rd; end
      endcase
   endtask

   task automatic sweep(input int st);
      for (int ki = 0; ki < 16; ki++) begin
         logic [5:0] iop, ifn; bit irs, irt, ictl; int idm;
         kind_info(ki, iop, ifn, irs, irt, idm, ictl);
         for (int ke = 0; ke < 16; ke++) begin
            logic [5:0] eop, efn; bit ers, ert, ectl; int edm;
            kind_info(ke, eop, efn, ers, ert, edm, ectl);
            for (int a = 0; a < 3; a++)
            for (int b = 0; b < 3; b++)
            for (int c = 0; c < 3; c++)
            for (int d = 0; d < 3; d++) begin
               logic [4:0] dv; bit raw, exp; string tag;
               id_valid = 1; id_op = iop; id_fn = ifn; id_rs = regval(a); id_rt = regval(b);
               set_stage(st, 1'b1, eop, efn, regval(c), regval(d));
               dv  = dest_of(edm, regval(c), regval(d));
               raw = (dv != 0) && ((irs && regval(a) == dv) || (irt && regval(b) == dv));
               if (st == 1)      exp = raw || ectl;
               else if (st == 2) exp = raw;
               else              exp = 1'b0;
               if (st == 3)              tag = "R3";
               else if (exp && !raw)     tag = "R7";
               else if (exp)             tag = (st == 1) ? "R1" : "R2";
               else if (edm == 0)        tag = "R5";
               else if (dv == 0)         tag = "R4";
               else                      tag = "R6";
               #2;
               check(exp, tag, $sformatf("stage%0d id_kind=%0d old_kind=%0d rs=%0d rt=%0d old_rt=%0d old_rd=%0d",
                                         st, ki, ke, regval(a), regval(b), regval(c), regval(d)));
               #2;
            end
         end
      end
      set_stage(st, 1'b0, 6'h00, 6'h00, 5'd0, 5'd0);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 190000) begin
         errors++;
         $display("FAIL R8 watchdog: run did not finish, cycles=%0d expected below 190000", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 0;
      clear_all();
      #6 rst_n = 1;
      #2;
      check(1'b0, "R8", "all stages empty after reset");
      #2;

      // R8: empty decode ignores a conflicting add and a branch in execute
      ex_valid = 1; ex_op = 6'h00; ex_fn = 6'h20; ex_rd = 5'd1;
      id_valid = 0; id_op = 6'h00; id_fn = 6'h20; id_rs = 5'd1; id_rt = 5'd1;
      #2 check(1'b0, "R8", "decode invalid with execute writer"); #2;
      ex_op = 6'h04;
      #2 check(1'b0, "R8", "decode invalid with branch in execute"); #2;
      // R8: invalid execute branch and invalid memory writer do nothing
      id_valid = 1; ex_valid = 0;
      mem_valid = 0; mem_op = 6'h00; mem_fn = 6'h20; mem_rd = 5'd1;
      #2 check(1'b0, "R8", "older stages invalid"); #2;
      // R5: jal in memory writes r31, read by jr in decode
      mem_valid = 1; mem_op = 6'h03; mem_fn = 6'h00;
      id_op = 6'h00; id_fn = 6'h08; id_rs = 5'd31; id_rt = 5'd0;
      #2 check(1'b1, "R5", "jal link register seen by jr"); #2;
      clear_all();

      sweep(1);
      sweep(2);
      sweep(3);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule